// File: doc/BRIEF.md
# EDO Page-Mode Burst Read Engine

This block reads a run of consecutive 16-bit words from a single row of an asynchronous DRAM with extended data out. It opens the row with one row-strobe assertion. It then pulses both column strobes together once per word and advances the column address by one each time. Because the device keeps its output valid after the column strobe rises, each word is latched on the clock edge where the column strobe falls for the following word. The last word is latched on the edge where the row strobe rises.

A requester pulses `start` with a row, a start column and a length. The engine returns one `rd_valid` strobe per word, in column order. It ends the burst with a one-cycle `done` pulse that carries the number of words actually read. A burst is cut short if it would run off the end of the row, or if it would hold the row open longer than the page-mode limit, which is given in nanoseconds and converted to clock cycles. All strobe timings are clock-cycle parameters. A length of zero finishes at once and never touches the DRAM.

Top module: `edo_burst_reader`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ras_n`, `ucas_n`, `lcas_n` and `oe_n` are 1, and `rd_valid` and `done` are 0.
- R2: A `start` sampled in idle with a non-zero effective length drives `ras_n` and `oe_n` low from the next cycle, with `addr` equal to `row`. `oe_n` stays low exactly as long as `ras_n` is low. The first column-strobe fall comes RCD_CYC cycles after the row-strobe fall.
- R3: Each word gets one column-strobe pulse: `ucas_n` and `lcas_n` are equal, they are low for CASL_CYC cycles, and they are high for CASH_CYC cycles between words. `addr[COL_W-1:0]` holds start column plus word index for every cycle the strobe is low.
- R4: For a burst of N words, word k with k < N-1 appears on `rd_data` with a one-cycle `rd_valid` after the edge where the strobe falls for word k+1. That is RCD_CYC + (k+1)*(CASL_CYC+CASH_CYC) edges after the start edge. Words come in column order.
- R5: The last word is latched on the edge where `ras_n` rises, which is TAIL_CYC cycles after the last strobe rise. On that same edge `done` pulses for one cycle with `done_count` = N. The full span from the start edge is RCD_CYC + (N-1)*(CASL_CYC+CASH_CYC) + CASL_CYC + TAIL_CYC.
- R6: N = min(len, 2^COL_W - col, burst limit). A burst never crosses the row end, and `done_count` reports the shortened N.
- R7: `ras_n` is never low for more than RAS_MAX_NS/CLK_NS consecutive cycles. The burst limit is the largest N whose span fits in that window.
- R8: With an effective length of zero, `done` pulses on the edge after `start` with `done_count` = 0, and `ras_n` never goes low.
- R9: `start` is ignored from the start edge until PRE_CYC cycles after `ras_n` rises. A pulse during that time opens no row and changes no result.
- R10: The column strobes are only low while `ras_n` is low, and `ras_n` only rises while they are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle burst request |
| row | input | ROW_W | Row to open |
| col | input | COL_W | First column of the burst |
| len | input | COL_W+1 | Requested word count |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | ROW_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Data from the DRAM |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | DATA_W | Captured word |
| done | output | 1 | One-cycle end-of-burst pulse |
| done_count | output | COL_W+1 | Words delivered by the burst |

## Verification
Every result has a fixed due cycle counted from the edge that samples `start`. The first strobe fall is due RCD_CYC edges later. Word k (k < N-1) is due RCD_CYC+(k+1)*(CASL_CYC+CASH_CYC) edges later. The last word and `done` share the edge at the full span. A zero-length `done` is due one edge later. The bench drives inputs and samples outputs on falling clock edges and numbers each falling edge from the start edge. Each strobe is compared with the falling-edge number it is due at, so a result that arrives early or late fails even when its data is correct.

// File: rtl/edo_burst_pkg.sv
package edo_burst_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RCD,
    PH_CASL,
    PH_CASH,
    PH_TAIL,
    PH_PRE
  } phase_e;
endpackage

// File: rtl/edo_len_clamp.sv
module edo_len_clamp #(
  parameter int COL_W     = 10,
  parameter int LEN_W     = 11,
  parameter int MAX_BURST = 1024
) (
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] eff_len
);
  localparam int COLS = 1 << COL_W;
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_BURST);

  logic [LEN_W-1:0] room;
  logic [LEN_W-1:0] by_row;

  always_comb begin
    room    = LEN_W'(COLS) - LEN_W'(col);
    by_row  = (len < room) ? len : room;
    eff_len = (by_row < LIMIT) ? by_row : LIMIT;
  end

  // R6: the shortened length never exceeds any of its three bounds
  always_comb begin
    if (!$isunknown({len, col})) begin
      a_r6_len_bounded: assert (eff_len <= len && eff_len <= room && eff_len <= LIMIT);
    end
  end
endmodule

// File: rtl/edo_phase_ctrl.sv
module edo_phase_ctrl
  import edo_burst_pkg::*;
#(
  parameter int ROW_W       = 12,
  parameter int COL_W       = 10,
  parameter int LEN_W       = 11,
  parameter int RCD_CYC     = 3,
  parameter int CASL_CYC    = 1,
  parameter int CASH_CYC    = 1,
  parameter int TAIL_CYC    = 3,
  parameter int PRE_CYC     = 3,
  parameter int RAS_MAX_CYC = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] eff_len,
  output logic             ras_n,
  output logic             cas_n,
  output logic             oe_n,
  output logic [ROW_W-1:0] addr,
  output logic             take_now,
  output logic             fin_now,
  output logic [LEN_W-1:0] fin_count
);
  localparam int MAXP_A = (RCD_CYC > CASL_CYC) ? RCD_CYC : CASL_CYC;
  localparam int MAXP_B = (CASH_CYC > TAIL_CYC) ? CASH_CYC : TAIL_CYC;
  localparam int MAXP_C = (MAXP_A > MAXP_B) ? MAXP_A : MAXP_B;
  localparam int MAXP   = (MAXP_C > PRE_CYC) ? MAXP_C : PRE_CYC;
  localparam int CNT_W  = $clog2(MAXP + 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] total_q;
  logic [COL_W-1:0] col_q;
  logic             cnt_zero;
  logic             idle_go;

  assign cnt_zero = (cnt_q == '0);
  assign idle_go  = (ph_q == PH_IDLE) && start;

  always_comb begin
    take_now  = cnt_zero && (ph_q == PH_CASH || ph_q == PH_TAIL);
    fin_now   = (cnt_zero && ph_q == PH_TAIL) || (idle_go && eff_len == '0);
    fin_count = (ph_q == PH_IDLE) ? '0 : total_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      total_q <= '0;
      col_q   <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      oe_n    <= 1'b1;
      addr    <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start && eff_len != '0) begin
            ras_n   <= 1'b0;
            oe_n    <= 1'b0;
            addr    <= row;
            col_q   <= col;
            left_q  <= eff_len;
            total_q <= eff_len;
            cnt_q   <= CNT_W'(RCD_CYC - 1);
            ph_q    <= PH_RCD;
          end
        end
        PH_RCD: begin
          if (cnt_zero) begin
            cas_n <= 1'b0;
            addr  <= ROW_W'(col_q);
            cnt_q <= CNT_W'(CASL_CYC - 1);
            ph_q  <= PH_CASL;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_CASL: begin
          if (cnt_zero) begin
            cas_n  <= 1'b1;
            col_q  <= col_q + 1'b1;
            addr   <= ROW_W'(col_q + 1'b1);
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) begin
              cnt_q <= CNT_W'(TAIL_CYC - 1);
              ph_q  <= PH_TAIL;
            end else begin
              cnt_q <= CNT_W'(CASH_CYC - 1);
              ph_q  <= PH_CASH;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_CASH: begin
          if (cnt_zero) begin
            cas_n <= 1'b0;
            cnt_q <= CNT_W'(CASL_CYC - 1);
            ph_q  <= PH_CASL;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_TAIL: begin
          if (cnt_zero) begin
            ras_n <= 1'b1;
            oe_n  <= 1'b1;
            cnt_q <= CNT_W'(PRE_CYC - 1);
            ph_q  <= PH_PRE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_PRE: begin
          if (cnt_zero) begin
            ph_q <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // Consecutive cycles the row has been open, for the R7 window check
  logic [31:0] span_q;
  always_ff @(posedge clk) begin
    if (rst)        span_q <= '0;
    else if (ras_n) span_q <= '0;
    else            span_q <= span_q + 1'b1;
  end

  a_r7_ras_window: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (span_q < 32'(RAS_MAX_CYC)));

  a_r2_row_opens: assert property (@(posedge clk) disable iff (rst)
    (idle_go && eff_len != '0) |=> (!ras_n && addr == $past(row)));

  a_r8_zero_keeps_row_closed: assert property (@(posedge clk) disable iff (rst)
    (idle_go && eff_len == '0) |=> ras_n);

  a_r10_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  a_r10_ras_rises_cas_high: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> cas_n);

  a_r3_cas_falls_after_row: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> !$past(ras_n));
endmodule

// File: rtl/edo_capture.sv
module edo_capture #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_now,
  input  logic              fin_now,
  input  logic [LEN_W-1:0]  fin_count,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [LEN_W-1:0]  done_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
      done_count <= '0;
    end else begin
      rd_valid <= take_now;
      if (take_now) rd_data <= dq_in;
      done <= fin_now;
      if (fin_now) done_count <= fin_count;
    end
  end

  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_count_held: assert property (@(posedge clk) disable iff (rst)
    !fin_now |=> $stable(done_count));
endmodule

// File: rtl/edo_burst_reader.sv
module edo_burst_reader #(
  parameter int DATA_W     = 16,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 10,
  parameter int CLK_NS     = 10,
  parameter int RCD_CYC    = 3,
  parameter int CASL_CYC   = 1,
  parameter int CASH_CYC   = 1,
  parameter int TAIL_CYC   = 3,
  parameter int PRE_CYC    = 3,
  parameter int RAS_MAX_NS = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [COL_W:0]    len,
  output logic              ras_n,
  output logic              ucas_n,
  output logic              lcas_n,
  output logic              oe_n,
  output logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [COL_W:0]    done_count
);
  localparam int LEN_W       = COL_W + 1;
  localparam int COLS        = 1 << COL_W;
  localparam int RAS_MAX_CYC = RAS_MAX_NS / CLK_NS;
  localparam int FIXED_CYC   = RCD_CYC + CASL_CYC + TAIL_CYC;
  localparam int PAGE_CYC    = CASL_CYC + CASH_CYC;
  localparam int FIT_WORDS   = (RAS_MAX_CYC >= FIXED_CYC) ?
                               (RAS_MAX_CYC - FIXED_CYC) / PAGE_CYC + 1 : 0;
  localparam int MAX_BURST   = (FIT_WORDS > COLS) ? COLS : FIT_WORDS;

  logic [LEN_W-1:0] eff_len;
  logic             cas_n;
  logic             take_now;
  logic             fin_now;
  logic [LEN_W-1:0] fin_count;

  edo_len_clamp #(
    .COL_W(COL_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST)
  ) clamp_i (
    .col(col), .len(len), .eff_len(eff_len)
  );

  edo_phase_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W),
    .RCD_CYC(RCD_CYC), .CASL_CYC(CASL_CYC), .CASH_CYC(CASH_CYC),
    .TAIL_CYC(TAIL_CYC), .PRE_CYC(PRE_CYC), .RAS_MAX_CYC(RAS_MAX_CYC)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .row(row), .col(col),
    .eff_len(eff_len), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .addr(addr), .take_now(take_now), .fin_now(fin_now),
    .fin_count(fin_count)
  );

  edo_capture #(
    .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) cap_i (
    .clk(clk), .rst(rst), .take_now(take_now), .fin_now(fin_now),
    .fin_count(fin_count), .dq_in(dq_in), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .done_count(done_count)
  );

  assign ucas_n = cas_n;
  assign lcas_n = cas_n;
endmodule

// File: tb/edo_burst_reader_tb.sv
module edo_burst_reader_tb_top;
  localparam int CLK_NS   = 10;
  localparam int RCD      = 3;
  localparam int CASL     = 1;
  localparam int CASH     = 1;
  localparam int TAIL     = 3;
  localparam int PRE      = 3;
  localparam int PAGE     = CASL + CASH;
  localparam int NVEC     = 7;
  localparam int V_ROW [NVEC] = '{5, 2748, 7, 3, 47, 1, 9};
  localparam int V_COL [NVEC] = '{0, 100, 1020, 1023, 50, 512, 0};
  localparam int V_LEN [NVEC] = '{4, 1, 10, 1, 0, 600, 1024};
  localparam int V_EXP [NVEC] = '{4, 1, 4, 1, 0, 512, 1024};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_a = 1'b0, start_s = 1'b0, sel = 1'b0;
  logic [11:0] row_i = '0;
  logic [9:0]  col_i = '0;
  logic [10:0] len_i = '0;
  logic [15:0] dq_m;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic a_ras, a_ucas, a_lcas, a_oe, a_valid, a_done;
  logic s_ras, s_ucas, s_lcas, s_oe, s_valid, s_done;
  logic [11:0] a_addr, s_addr;
  logic [15:0] a_data, s_data;
  logic [10:0] a_cnt, s_cnt;

  always #(CLK_NS / 2) clk = ~clk;

  edo_burst_reader #(
    .CLK_NS(CLK_NS), .RCD_CYC(RCD), .CASL_CYC(CASL), .CASH_CYC(CASH),
    .TAIL_CYC(TAIL), .PRE_CYC(PRE), .RAS_MAX_NS(100000)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start_a), .row(row_i), .col(col_i),
    .len(len_i), .ras_n(a_ras), .ucas_n(a_ucas), .lcas_n(a_lcas),
    .oe_n(a_oe), .addr(a_addr), .dq_in(dq_m), .rd_valid(a_valid),
    .rd_data(a_data), .done(a_done), .done_count(a_cnt)
  );

  // Second copy with a 200 ns row window (20 cycles)
  edo_burst_reader #(
    .CLK_NS(CLK_NS), .RCD_CYC(RCD), .CASL_CYC(CASL), .CASH_CYC(CASH),
    .TAIL_CYC(TAIL), .PRE_CYC(PRE), .RAS_MAX_NS(200)
  ) dut_s (
    .clk(clk), .rst(rst), .start(start_s), .row(row_i), .col(col_i),
    .len(len_i), .ras_n(s_ras), .ucas_n(s_ucas), .lcas_n(s_lcas),
    .oe_n(s_oe), .addr(s_addr), .dq_in(dq_m), .rd_valid(s_valid),
    .rd_data(s_data), .done(s_done), .done_count(s_cnt)
  );

  logic m_ras, m_ucas, m_lcas, m_oe, m_valid, m_done;
  logic [11:0] m_addr;
  logic [15:0] m_data;
  logic [10:0] m_cnt;
  assign m_ras   = sel ? s_ras   : a_ras;
  assign m_ucas  = sel ? s_ucas  : a_ucas;
  assign m_lcas  = sel ? s_lcas  : a_lcas;
  assign m_oe    = sel ? s_oe    : a_oe;
  assign m_addr  = sel ? s_addr  : a_addr;
  assign m_valid = sel ? s_valid : a_valid;
  assign m_data  = sel ? s_data  : a_data;
  assign m_done  = sel ? s_done  : a_done;
  assign m_cnt   = sel ? s_cnt   : a_cnt;

  function automatic logic [15:0] pat(input logic [11:0] r, input logic [9:0] c);
    return {r[5:0], c} ^ 16'h5A3C;
  endfunction

  // DRAM model: row and column latched on strobe falls, data held until the row closes
  logic [11:0] row_lat = '0;
  logic [9:0]  col_lat = '0;
  int ep_ras = 0, ep_cas = -1;
  always @(negedge m_ras) begin
    row_lat <= m_addr;
    ep_ras  <= ep_ras + 1;
  end
  always @(negedge m_ucas) if (!m_ras) begin
    col_lat <= m_addr[9:0];
    ep_cas  <= ep_ras;
  end
  assign dq_m = (!m_ras && ep_cas == ep_ras) ? pat(row_lat, col_lat) : 16'hFFFF;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input bit use_s, input int r, input int c0,
                           input int n_len, input int exp_n, input bit poke);
    int cyc, got, low_ras, cas_low, falls, bad, done_at, done_cnt, span, due, quiet;
    logic prev_cas;
    cyc = 1; got = 0; low_ras = 0; cas_low = 0; falls = 0; bad = 0;
    done_at = -1; done_cnt = -1; quiet = 0; prev_cas = 1'b1;
    span = RCD + (exp_n - 1) * PAGE + CASL + TAIL;
    sel = use_s; row_i = 12'(r); col_i = 10'(c0); len_i = 11'(n_len);
    if (use_s) start_s = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0; start_s = 1'b0;
    while (done_at < 0 && cyc < 6000) begin
      if (poke && cyc == 2) begin
        row_i = 12'd8; len_i = 11'd9;
        if (use_s) start_s = 1'b1; else start_a = 1'b1;
      end else begin
        start_a = 1'b0; start_s = 1'b0;
      end
      if (!m_ras) begin
        low_ras++;
        if (m_oe) bad++;
        if (cyc == 1 && m_addr != 12'(r)) bad++;
      end else if (!m_oe) bad++;
      if (m_ucas != m_lcas) bad++;
      if (!m_ucas) begin
        cas_low++;
        if (m_ras) bad++;
        if (prev_cas) begin
          falls++;
          if (falls == 1 && cyc != RCD + 1) bad++;
        end
        if (m_addr[9:0] != 10'(c0 + falls - 1)) bad++;
      end
      if (m_valid) begin
        due = (got < exp_n - 1) ? RCD + (got + 1) * PAGE + 1 : span + 1;
        chk(m_data == pat(12'(r), 10'(c0 + got)), (got < exp_n - 1) ? "R4" : "R5",
            "word data", int'(m_data), int'(pat(12'(r), 10'(c0 + got))));
        chk(cyc == due, (got < exp_n - 1) ? "R4" : "R5", "word cycle", cyc, due);
        got++;
      end
      if (m_done) begin
        done_at = cyc;
        done_cnt = int'(m_cnt);
      end
      prev_cas = m_ucas;
      @(negedge clk);
      cyc++;
    end
    start_a = 1'b0; start_s = 1'b0;
    chk(done_at == ((exp_n == 0) ? 1 : span + 1), (exp_n == 0) ? "R8" : "R5",
        "done cycle", done_at, (exp_n == 0) ? 1 : span + 1);
    chk(done_cnt == exp_n, "R6", "done_count", done_cnt, exp_n);
    chk(got == exp_n, "R4", "words delivered", got, exp_n);
    chk(low_ras == ((exp_n == 0) ? 0 : span), (exp_n == 0) ? "R8" : "R2",
        "row-open cycles", low_ras, (exp_n == 0) ? 0 : span);
    chk(cas_low == exp_n * CASL, "R3", "strobe-low cycles", cas_low, exp_n * CASL);
    chk(bad == 0, "R10", "pin sequence violations", bad, 0);
    for (int i = 0; i < PRE + 5; i++) begin
      if (!m_ras || m_valid || m_done) quiet++;
      @(negedge clk);
    end
    chk(quiet == 0, "R9", "activity after burst", quiet, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog expired: actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk({a_ras, a_ucas, a_lcas, a_oe, a_valid, a_done} == 6'b111100, "R1",
        "reset pins main", int'({a_ras, a_ucas, a_lcas, a_oe, a_valid, a_done}), 'b111100);
    chk({s_ras, s_ucas, s_lcas, s_oe, s_valid, s_done} == 6'b111100, "R1",
        "reset pins small", int'({s_ras, s_ucas, s_lcas, s_oe, s_valid, s_done}), 'b111100);
    rst = 1'b0;
    @(negedge clk);
    chk(a_ras && a_oe && !a_done, "R1", "first cycle after reset",
        int'({a_ras, a_oe, a_done}), 'b110);

    for (int v = 0; v < NVEC; v++) begin
      run_burst(1'b0, V_ROW[v], V_COL[v], V_LEN[v], V_EXP[v], 1'b0);
    end

    // R7: 20-cycle window allows 7 words; R6 still applies inside it
    run_burst(1'b1, 2, 0, 20, 7, 1'b0);
    run_burst(1'b1, 6, 1020, 20, 4, 1'b0);
    run_burst(1'b1, 11, 300, 3, 3, 1'b0);
    // R9: a start pulse while busy leaves the burst unchanged
    run_burst(1'b0, 4, 10, 3, 3, 1'b1);
    // R8: zero length on the limited copy as well
    run_burst(1'b1, 1, 0, 0, 0, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule